// File: doc/BRIEF.md
# Debug-Port Instruction Decoder with Address Pointer

This block sits behind the byte-level link layer of a serial debug and programming port. Each received byte is either an instruction opcode or an operand of the instruction in progress. The decoder keeps a 32-bit address pointer and a 16-bit repeat count. It turns indirect load and store instructions into single-byte requests on a simple internal memory bus. Read data from the bus goes back to the link layer as a response byte with a valid strobe.

Four instructions are decoded. Pointer load (0x6B) takes four operand bytes, most significant byte first. Indirect store with post-increment (0x67) takes one data byte. Repeat (0xA1) takes two operand bytes, least significant byte first. Indirect load with post-increment (0x27) takes no operand. A repeat count N makes the next indirect access run N+1 times, after which the count returns to zero. Any other opcode byte is dropped.

The memory bus returns read data in the cycle after the read request.

Top module: `dbgp_decoder`

## Requirements
- R1: While reset is asserted and in the first cycle after it, bus_we, bus_re and rsp_valid are low. The pointer and the repeat count are zero, so an indirect load issued first reads address 0x00000000 exactly once.
- R2: Opcode 0x6B followed by four operand bytes B0..B3 sets the pointer to {B0,B1,B2,B3}, with the first byte as bits 31:24.
- R3: Opcode 0x67 followed by data byte D drives bus_we high for one cycle, with bus_addr equal to the pointer and bus_wdata equal to D. This happens in the cycle after D is accepted, and the pointer then advances by one.
- R4: Opcode 0x27 drives bus_re high for one cycle, with bus_addr equal to the pointer, in the cycle after the opcode is accepted, and the pointer then advances by one. bus_rdata is taken in the cycle after bus_re. rsp_valid is high with that byte on rsp_byte in the cycle after that.
- R5: Opcode 0xA1 followed by bytes L and H sets the repeat count to {H,L}, with the first byte as the low byte.
- R6: With repeat count N, the next 0x67 takes N+1 data bytes. Each byte is written to successive addresses one cycle after it is accepted, and the count is then zero.
- R7: With repeat count N, the next 0x27 issues N+1 reads in consecutive cycles at successive addresses and yields N+1 responses. The count is then zero. Bytes that arrive during this read burst are dropped.
- R8: The pointer increments modulo 2^32, so 0xFFFFFFFF is followed by 0x00000000.
- R9: An opcode byte other than 0x6B, 0x67, 0xA1 or 0x27 causes no bus access and no change to the pointer or the count. The next byte is decoded as an opcode.
- R10: Operand bytes are counted and are never decoded as opcodes, even when their value equals an opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte from the link layer |
| bus_addr | output | 32 | Memory bus address |
| bus_wdata | output | 8 | Memory bus write data |
| bus_we | output | 1 | Single-cycle write request |
| bus_re | output | 1 | Single-cycle read request |
| bus_rdata | input | 8 | Read data, valid the cycle after bus_re |
| rsp_valid | output | 1 | Response byte valid strobe |
| rsp_byte | output | 8 | Response byte to the link layer |

## Verification
A write request is due in the cycle after its data byte is accepted. A read request is due in the cycle after its opcode is accepted, or in the cycle after the previous read of a burst. The matching response is due two cycles after that read. The bench's reference model steps at every rising edge and advances its own outputs through the same latencies, built from queued operand bytes and integer counters. All outputs are compared at the falling edge of every clock, so a result that comes one cycle early or late is reported as a mismatch. Operand values equal to opcodes, wrap-around, long repeat bursts and a reset in mid-run are each driven through this comparison.

// File: rtl/dbgp_pkg.sv
package dbgp_pkg;
  localparam logic [7:0] OP_SET_PTR  = 8'h6B;
  localparam logic [7:0] OP_ST_INC   = 8'h67;
  localparam logic [7:0] OP_SET_RPT  = 8'h A1;
  localparam logic [7:0] OP_LD_INC   = 8'h27;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PTR_OPND,
    S_RPT_OPND,
    S_ST_DATA,
    S_LD_BURST
  } seq_state_t;
endpackage

// File: rtl/dbgp_ptr.sv
module dbgp_ptr #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [ADDR_W-1:0] ld_val,
  input  logic              inc,
  output logic [ADDR_W-1:0] ptr
);
  logic [ADDR_W-1:0] ptr_nx;

  always_comb begin
    ptr_nx = ptr;
    if (ld)       ptr_nx = ld_val;
    else if (inc) ptr_nx = ptr + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ptr <= '0;
    else if (ld || inc) ptr <= ptr_nx;
  end
endmodule

// File: rtl/dbgp_rpt.sv
module dbgp_rpt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_nx;

  always_comb begin
    cnt_nx = cnt;
    if (ld)       cnt_nx = ld_val;
    else if (clr) cnt_nx = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (ld || clr) cnt <= cnt_nx;
  end
endmodule

// File: rtl/dbgp_seq.sv
module dbgp_seq
  import dbgp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic [CNT_W-1:0]  rpt_cnt,
  output logic              ptr_ld,
  output logic [ADDR_W-1:0] ptr_ld_val,
  output logic              ptr_inc,
  output logic              rpt_ld,
  output logic [CNT_W-1:0]  rpt_ld_val,
  output logic              rpt_clr,
  output logic              do_wr,
  output logic              do_rd
);
  localparam int PTR_BYTES = ADDR_W / 8;
  localparam int RPT_BYTES = CNT_W / 8;
  localparam int IDX_W     = $clog2(PTR_BYTES + 1);

  seq_state_t        state, state_nx;
  logic [IDX_W-1:0]  idx, idx_nx;
  logic [ADDR_W-1:0] acc, acc_nx;
  logic [CNT_W-1:0]  left, left_nx;

  always_comb begin
    state_nx   = state;
    idx_nx     = idx;
    acc_nx     = acc;
    left_nx    = left;
    ptr_ld     = 1'b0;
    ptr_inc    = 1'b0;
    rpt_ld     = 1'b0;
    rpt_clr    = 1'b0;
    do_wr      = 1'b0;
    do_rd      = 1'b0;
    ptr_ld_val = {acc[ADDR_W-9:0], rx_byte};
    rpt_ld_val = {rx_byte, acc[CNT_W-1:8]};
    case (state)
      S_IDLE: begin
        if (rx_valid) begin
          idx_nx = '0;
          case (rx_byte)
            OP_SET_PTR: state_nx = S_PTR_OPND;
            OP_SET_RPT: state_nx = S_RPT_OPND;
            OP_ST_INC: begin
              state_nx = S_ST_DATA;
              left_nx  = rpt_cnt;
              rpt_clr  = 1'b1;
            end
            OP_LD_INC: begin
              do_rd    = 1'b1;
              ptr_inc  = 1'b1;
              rpt_clr  = 1'b1;
              left_nx  = rpt_cnt;
              state_nx = (rpt_cnt != '0) ? S_LD_BURST : S_IDLE;
            end
            default: state_nx = S_IDLE;
          endcase
        end
      end
      S_PTR_OPND: begin
        if (rx_valid) begin
          acc_nx = {acc[ADDR_W-9:0], rx_byte};
          idx_nx = idx + IDX_W'(1);
          if (idx == IDX_W'(PTR_BYTES - 1)) begin
            ptr_ld   = 1'b1;
            state_nx = S_IDLE;
          end
        end
      end
      S_RPT_OPND: begin
        if (rx_valid) begin
          acc_nx[CNT_W-1:0] = {rx_byte, acc[CNT_W-1:8]};
          idx_nx = idx + IDX_W'(1);
          if (idx == IDX_W'(RPT_BYTES - 1)) begin
            rpt_ld   = 1'b1;
            state_nx = S_IDLE;
          end
        end
      end
      S_ST_DATA: begin
        if (rx_valid) begin
          do_wr   = 1'b1;
          ptr_inc = 1'b1;
          if (left == '0) state_nx = S_IDLE;
          else            left_nx  = left - CNT_W'(1);
        end
      end
      S_LD_BURST: begin
        do_rd   = 1'b1;
        ptr_inc = 1'b1;
        left_nx = left - CNT_W'(1);
        if (left == CNT_W'(1)) state_nx = S_IDLE;
      end
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      idx   <= '0;
      acc   <= '0;
      left  <= '0;
    end else begin
      state <= state_nx;
      idx   <= idx_nx;
      acc   <= acc_nx;
      left  <= left_nx;
    end
  end
endmodule

// File: rtl/dbgp_decoder.sv
module dbgp_decoder #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  output logic              bus_we,
  output logic              bus_re,
  input  logic [7:0]        bus_rdata,
  output logic              rsp_valid,
  output logic [7:0]        rsp_byte
);
  logic              ptr_ld, ptr_inc, rpt_ld, rpt_clr, do_wr, do_rd;
  logic [ADDR_W-1:0] ptr_ld_val, ptr;
  logic [CNT_W-1:0]  rpt_ld_val, rpt_cnt;
  logic              rd_pend;

  dbgp_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_byte    (rx_byte),
    .rpt_cnt    (rpt_cnt),
    .ptr_ld     (ptr_ld),
    .ptr_ld_val (ptr_ld_val),
    .ptr_inc    (ptr_inc),
    .rpt_ld     (rpt_ld),
    .rpt_ld_val (rpt_ld_val),
    .rpt_clr    (rpt_clr),
    .do_wr      (do_wr),
    .do_rd      (do_rd)
  );

  dbgp_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (ptr_ld),
    .ld_val (ptr_ld_val),
    .inc    (ptr_inc),
    .ptr    (ptr)
  );

  dbgp_rpt #(.CNT_W(CNT_W)) u_rpt (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (rpt_ld),
    .ld_val (rpt_ld_val),
    .clr    (rpt_clr),
    .cnt    (rpt_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_we    <= 1'b0;
      bus_re    <= 1'b0;
      rd_pend   <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      bus_we    <= do_wr;
      bus_re    <= do_rd;
      rd_pend   <= bus_re;
      rsp_valid <= rd_pend;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_addr  <= '0;
      bus_wdata <= '0;
      rsp_byte  <= '0;
    end else begin
      if (do_wr || do_rd) bus_addr  <= ptr;
      if (do_wr)          bus_wdata <= rx_byte;
      if (rd_pend)        rsp_byte  <= bus_rdata;
    end
  end
endmodule

// File: rtl/dbgp_chk.sv
module dbgp_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic              bus_re,
  input logic              rsp_valid
);
  // R1: outputs quiet while reset is held
  always_comb begin
    if (!rst_n) begin
      a_r1_quiet_in_reset: assert (!bus_we && !bus_re && !rsp_valid);
    end
  end

  a_r3_single_access: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_re));

  a_r4_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_re, 2) |-> rsp_valid);

  a_r4_rsp_has_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(bus_re, 2));

  a_r6_store_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && $past(bus_we)) |-> bus_addr == $past(bus_addr) + ADDR_W'(1));

  a_r7_burst_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && $past(bus_re)) |-> bus_addr == $past(bus_addr) + ADDR_W'(1));

  a_r10_write_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> $past(rx_valid));
endmodule

bind dbgp_decoder dbgp_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_valid  (rx_valid),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_re    (bus_re),
  .rsp_valid (rsp_valid)
);

// File: tb/dbgp_decoder_tb.sv
module dbgp_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic [31:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_we, bus_re;
  logic [7:0]  bus_rdata = 8'h00;
  logic        rsp_valid;
  logic [7:0]  rsp_byte;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #4 clk = ~clk;

  dbgp_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_re(bus_re), .bus_rdata(bus_rdata), .rsp_valid(rsp_valid),
    .rsp_byte(rsp_byte)
  );

  function automatic logic [7:0] mem_val(logic [31:0] a);
    return a[7:0] ^ a[23:16] ^ {a[30:27], a[3:0]} ^ 8'hC3;
  endfunction

  // memory: read data valid the cycle after the request
  always @(posedge clk) if (bus_re) bus_rdata <= mem_val(bus_addr);

  // behavioural reference model
  bit [31:0] m_ptr;
  int        m_rpt, m_mode, m_left;
  byte unsigned opq[$];
  bit        e_we, e_re, e_rspv, e_rd1;
  bit [31:0] e_addr, e_rd1_addr;
  bit [7:0]  e_wdata, e_rsp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ptr = 0; m_rpt = 0; m_mode = 0; m_left = 0; opq.delete();
      e_we = 0; e_re = 0; e_rspv = 0; e_rd1 = 0;
      e_addr = 0; e_rd1_addr = 0; e_wdata = 0; e_rsp = 0;
    end else begin
      e_rspv = e_rd1;
      if (e_rd1) e_rsp = mem_val(e_rd1_addr);
      e_rd1 = e_re;
      e_rd1_addr = e_addr;
      e_we = 0; e_re = 0;
      if (m_mode == 4) begin
        e_re = 1; e_addr = m_ptr; m_ptr = m_ptr + 1;
        m_left = m_left - 1;
        if (m_left == 0) m_mode = 0;
      end else if (rx_valid) begin
        if (m_mode == 0) begin
          opq.delete();
          if (rx_byte == 8'h6B) m_mode = 1;
          else if (rx_byte == 8'hA1) m_mode = 2;
          else if (rx_byte == 8'h67) begin m_mode = 3; m_left = m_rpt; m_rpt = 0; end
          else if (rx_byte == 8'h27) begin
            e_re = 1; e_addr = m_ptr; m_ptr = m_ptr + 1;
            m_left = m_rpt; m_rpt = 0;
            m_mode = (m_left > 0) ? 4 : 0;
          end
        end else if (m_mode == 1) begin
          opq.push_back(rx_byte);
          if (opq.size() == 4) begin
            m_ptr = {opq[0], opq[1], opq[2], opq[3]};
            m_mode = 0;
          end
        end else if (m_mode == 2) begin
          opq.push_back(rx_byte);
          if (opq.size() == 2) begin
            m_rpt = int'(opq[0]) + 256 * int'(opq[1]);
            m_mode = 0;
          end
        end else if (m_mode == 3) begin
          e_we = 1; e_addr = m_ptr; e_wdata = rx_byte; m_ptr = m_ptr + 1;
          if (m_left == 0) m_mode = 0;
          else m_left = m_left - 1;
        end
      end
    end
  end

  task automatic chk(bit ok, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  // compare every cycle at the falling edge
  always @(negedge clk) begin
    if (!done) begin
      cycles++;
      chk(bus_we === e_we, "bus_we", 32'(bus_we), 32'(e_we));
      chk(bus_re === e_re, "bus_re", 32'(bus_re), 32'(e_re));
      chk(rsp_valid === e_rspv, "rsp_valid", 32'(rsp_valid), 32'(e_rspv));
      if (e_we || e_re) chk(bus_addr === e_addr, "bus_addr", bus_addr, e_addr);
      if (e_we) chk(bus_wdata === e_wdata, "bus_wdata", 32'(bus_wdata), 32'(e_wdata));
      if (e_rspv) chk(rsp_byte === e_rsp, "rsp_byte", 32'(rsp_byte), 32'(e_rsp));
      if (cycles > 150000) begin
        failures++;
        $display("FAIL %s watchdog expired actual=%0d expected=%0d", cur_req, cycles, 150000);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  task automatic send(logic [7:0] b);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_ptr(logic [31:0] p);
    send(8'h6B); send(p[31:24]); send(p[23:16]); send(p[15:8]); send(p[7:0]);
  endtask

  initial begin
    cur_req = "R1";
    idle(3);
    rst_n = 1'b1;
    idle(2);
    send(8'h27);              // R1: first read hits address 0
    idle(4);

    cur_req = "R2";
    set_ptr(32'h12345678);
    send(8'h27);
    idle(4);

    cur_req = "R3";
    send(8'h67); send(8'hFF);
    idle(1);
    send(8'h67); idle(2); send(8'h5A);
    idle(3);

    cur_req = "R4";
    send(8'h27); send(8'h27); idle(1); send(8'h27);
    idle(5);

    cur_req = "R9";
    send(8'h55); send(8'h00); send(8'hFF);
    send(8'h27);
    idle(4);

    cur_req = "R10";
    set_ptr(32'h2767A16B);
    send(8'h27);
    idle(4);

    cur_req = "R5";
    send(8'hA1); send(8'h03); send(8'h00);
    cur_req = "R6";
    send(8'h67); send(8'h11); send(8'h22); idle(2); send(8'h33); send(8'h44);
    idle(2);
    send(8'h67); send(8'h99);   // count back to zero: single write
    idle(3);

    cur_req = "R7";
    send(8'hA1); send(8'h02); send(8'h01);   // 0x0102 -> 259 reads
    send(8'h27);
    idle(270);

    cur_req = "R8";
    set_ptr(32'hFFFFFFFE);
    send(8'hA1); send(8'h03); send(8'h00);
    send(8'h27);
    idle(8);
    send(8'h67); send(8'h0F);
    idle(3);

    cur_req = "R1";
    set_ptr(32'hCAFE0000);
    send(8'hA1); send(8'h07);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    send(8'h27);
    idle(5);
    send(8'h67); send(8'hA5);
    idle(3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule